// File: doc/BRIEF.md
# Nth-Occurrence One-Shot Coincidence Monitor

This block is a synthesizable run-time monitor for two single-bit signals. One is an event strobe and the other is a one-time response strobe. Both are sampled on every rising clock edge. The monitor counts the cycles in which the event is high. It requires the response to be high in exactly one cycle: the cycle that carries the Nth event. The response must be low in every other cycle, from the first cycle after reset onward.

The events may arrive back to back or thousands of cycles apart, so no gap limit or timeout applies. Each rule that can break has its own sticky flag, which holds until the next reset. A code output tells which rule broke first. A pass output goes high once the coincidence has happened cleanly, and it drops if a violation follows. The current event count is also brought out.

The block is meant to sit beside the logic that produces the two strobes, as a permanent on-chip check.

Top module: `nthc_monitor`

## Requirements
- R1: While `rst_n` is sampled low, the next edge clears `occ_count_o`, `viol_flags_o`, `viol_code_o` and `pass_o` to zero.
- R2: If `rsp_i` is sampled high in the first cycle after `rst_n` rises, flag bit 0 (initial) is set and the code becomes 1.
- R3: `occ_count_o` counts the edges where `ev_i` is sampled high, whatever gap lies between them. It stops at `OCC_TARGET` and never wraps.
- R4: If `ev_i` and `rsp_i` are both high on the edge that carries the `OCC_TARGET`-th event, and no rule has fired, `pass_o` is high after that edge.
- R5: If the `OCC_TARGET`-th event is sampled with `rsp_i` low, flag bit 2 (missed) is set and the code becomes 3.
- R6: If `rsp_i` is sampled high together with an event before the `OCC_TARGET`-th one, flag bit 1 (early) is set and the code becomes 2.
- R7: If `rsp_i` is sampled high while `ev_i` is low, flag bit 3 (orphan) is set and the code becomes 4.
- R8: If `rsp_i` is sampled high on any edge after the `OCC_TARGET`-th event, flag bit 4 (repeat) is set, the code becomes 5 and `pass_o` falls.
- R9: Flags stay set until reset. The code keeps the first rule that fired. When several rules fire on one edge, the code takes the lowest flag bit among them, and all of their flags are set.
- R10: Every reset re-arms the initial check (R2) for the first cycle after that reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_i | input | 1 | Event strobe being counted |
| rsp_i | input | 1 | One-shot response strobe |
| viol_flags_o | output | 5 | Sticky flags: bit0 initial, bit1 early, bit2 missed, bit3 orphan, bit4 repeat |
| viol_code_o | output | 3 | First rule fired: 0 none, 1 initial, 2 early, 3 missed, 4 orphan, 5 repeat |
| pass_o | output | 1 | Clean coincidence seen and no violation since reset |
| occ_count_o | output | $clog2(OCC_TARGET+1) | Saturating count of events |

## Verification
The assertions take for granted that `rst_n` is held low for at least one edge at the start. They also assume `ev_i` and `rsp_i` are defined, settled values at every edge after that.

The stimulus changes both strobes one time unit after a rising edge and holds them for the whole cycle. Every scenario begins with a fresh reset, so the sticky state of one scenario never leaks into the next.

One scenario puts a gap of several thousand idle cycles between events. This shows that no timeout is assumed.

// File: rtl/nthc_pkg.sv
// Package for the Nth-occurrence coincidence monitor.
// Holds the rule bit positions, the violation codes, and the function
// that turns a set of rules fired on one edge into the code to report.
// Assumes five rules. Code value = rule bit position + 1.
package nthc_pkg;

    localparam int RULES    = 5;
    localparam int B_INIT   = 0;
    localparam int B_EARLY  = 1;
    localparam int B_MISSED = 2;
    localparam int B_ORPHAN = 3;
    localparam int B_REPEAT = 4;

    typedef enum logic [2:0] {
        CODE_NONE   = 3'd0,
        CODE_INIT   = 3'd1,
        CODE_EARLY  = 3'd2,
        CODE_MISSED = 3'd3,
        CODE_ORPHAN = 3'd4,
        CODE_REPEAT = 3'd5
    } nthc_code_e;

    // The lowest set rule bit wins; an empty set gives CODE_NONE.
    function automatic nthc_code_e first_rule(input logic [RULES-1:0] hits);
        nthc_code_e c;
        c = CODE_NONE;
        for (int i = RULES - 1; i >= 0; i--) begin
            if (hits[i]) c = nthc_code_e'(3'(i + 1));
        end
        return c;
    endfunction

endpackage

// File: rtl/nthc_occ_counter.sv
// Saturating counter of the edges where the event strobe is high.
// Assumes OCC_TARGET >= 1. The count stops at OCC_TARGET and never wraps.
// Reset is synchronous and active low.
module nthc_occ_counter #(
    parameter int OCC_TARGET = 5,
    localparam int CW = $clog2(OCC_TARGET + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_i,
    output logic [CW-1:0] cnt_o,
    output logic          at_last_o,   // next event is the target one
    output logic          full_o       // target event already counted
);
    localparam logic [CW-1:0] FULL = CW'(OCC_TARGET);
    localparam logic [CW-1:0] LAST = CW'(OCC_TARGET - 1);

    logic [CW-1:0] cnt_q;

    // Count sampled events until the target is reached.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (ev_i && cnt_q != FULL) cnt_q <= cnt_q + CW'(1);
    end

    assign cnt_o     = cnt_q;
    assign at_last_o = (cnt_q == LAST);
    assign full_o    = (cnt_q == FULL);

    // R3: the count never goes past the target.
    assert_count_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);

    // R3: an event below the target adds exactly one.
    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i && cnt_q != FULL |=> cnt_q == $past(cnt_q) + CW'(1));

    // R3: once saturated, the count holds.
    assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q == FULL |=> cnt_q == FULL);
endmodule

// File: rtl/nthc_rule_eval.sv
// Decides which rules the sampled strobes break on this edge, and whether
// this edge is the clean target coincidence.
// Holds one register: the arm bit for the check on the first cycle after
// reset. Everything else is combinational on the sampled inputs and the
// counter state.
module nthc_rule_eval (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ev_i,
    input  logic                     rsp_i,
    input  logic                     at_last_i,
    input  logic                     full_i,
    output logic [nthc_pkg::RULES-1:0] hits_o,
    output logic                     good_o
);
    import nthc_pkg::*;

    logic arm_q;

    // Arm the initial-value check during reset; disarm after one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) arm_q <= 1'b1;
        else        arm_q <= 1'b0;
    end

    // Classify this edge against every rule.
    always_comb begin
        hits_o           = '0;
        hits_o[B_INIT]   = arm_q && rsp_i;
        hits_o[B_EARLY]  = ev_i && rsp_i && !at_last_i && !full_i;
        hits_o[B_MISSED] = ev_i && at_last_i && !rsp_i;
        hits_o[B_ORPHAN] = rsp_i && !ev_i;
        hits_o[B_REPEAT] = rsp_i && full_i;
        good_o           = ev_i && rsp_i && at_last_i;
    end

    // R5/R6: early and missed can never both fire on one edge.
    assert_early_missed_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(hits_o[B_EARLY] && hits_o[B_MISSED]));

    // R4: a clean coincidence breaks none of the event-side rules.
    assert_good_is_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
        good_o |-> !hits_o[B_EARLY] && !hits_o[B_MISSED] && !hits_o[B_REPEAT]);
endmodule

// File: rtl/nthc_verdict.sv
// Keeps the sticky violation flags, the first-fired code and the pass bit.
// Assumes hits_i and good_i describe the current edge. Reset is synchronous
// and active low.
module nthc_verdict (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [nthc_pkg::RULES-1:0] hits_i,
    input  logic                       good_i,
    output logic [nthc_pkg::RULES-1:0] flags_o,
    output logic [2:0]                 code_o,
    output logic                       pass_o
);
    import nthc_pkg::*;

    logic [RULES-1:0] flags_q;
    nthc_code_e       code_q;
    logic             pass_q;

    // Accumulate flags; latch the code once; track the clean pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            code_q  <= CODE_NONE;
            pass_q  <= 1'b0;
        end else begin
            flags_q <= flags_q | hits_i;
            if (code_q == CODE_NONE) code_q <= first_rule(hits_i);
            pass_q  <= (pass_q || good_i) && (hits_i == '0) && (flags_q == '0);
        end
    end

    assign flags_o = flags_q;
    assign code_o  = code_q;
    assign pass_o  = pass_q;

    // R9: a flag, once set, stays set.
    assert_flags_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (flags_q & $past(flags_q)) == $past(flags_q));

    // R9: a code is reported exactly when some flag is set.
    assert_code_matches_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q != CODE_NONE) == (flags_q != '0));

    // R9: a reported code never changes before reset.
    assert_code_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        code_q != CODE_NONE |=> $stable(code_q));

    // R8: pass and any violation are never shown together.
    assert_pass_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_q && flags_q != '0));
endmodule

// File: rtl/nthc_monitor.sv
// Top of the Nth-occurrence one-shot coincidence monitor.
// Counts sampled events and requires the response strobe to be high on
// exactly the OCC_TARGET-th event edge and on no other edge. Reports sticky
// flags, the first-fired code and a pass bit.
// Assumes rst_n is held low for at least one edge at start-up.
module nthc_monitor #(
    parameter int OCC_TARGET = 5
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              ev_i,
    input  logic                              rsp_i,
    output logic [4:0]                        viol_flags_o,
    output logic [2:0]                        viol_code_o,
    output logic                              pass_o,
    output logic [$clog2(OCC_TARGET+1)-1:0]   occ_count_o
);
    import nthc_pkg::*;

    localparam int CW = $clog2(OCC_TARGET + 1);

    logic             at_last;
    logic             full;
    logic [RULES-1:0] hits;
    logic             good;

    nthc_occ_counter #(.OCC_TARGET(OCC_TARGET)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_i      (ev_i),
        .cnt_o     (occ_count_o),
        .at_last_o (at_last),
        .full_o    (full)
    );

    nthc_rule_eval u_eval (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_i      (ev_i),
        .rsp_i     (rsp_i),
        .at_last_i (at_last),
        .full_i    (full),
        .hits_o    (hits),
        .good_o    (good)
    );

    nthc_verdict u_verdict (
        .clk     (clk),
        .rst_n   (rst_n),
        .hits_i  (hits),
        .good_i  (good),
        .flags_o (viol_flags_o),
        .code_o  (viol_code_o),
        .pass_o  (pass_o)
    );

    // R7: a response without an event always leaves the orphan flag set.
    assert_orphan_flagged_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_i && !ev_i |=> viol_flags_o[B_ORPHAN]);

    // R8: a response after the target count always leaves the repeat flag set.
    assert_repeat_flagged_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_i && occ_count_o == CW'(OCC_TARGET) |=> viol_flags_o[B_REPEAT] && !pass_o);

    // R1: a reset edge leaves every output cleared.
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> occ_count_o == '0 && viol_flags_o == '0 && viol_code_o == 3'd0 && !pass_o);
endmodule

// File: tb/nthc_monitor_test.sv
// Directed bench for nthc_monitor. One task per scenario, each checking its
// own results. Inputs change 1 ns after a rising edge; outputs are read there.
module nthc_monitor_test;
    localparam int N = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev = 1'b0;
    logic       rsp = 1'b0;
    logic [4:0] flags;
    logic [2:0] code;
    logic       pass;
    logic [2:0] cnt;

    int checks = 0;
    int fails  = 0;

    nthc_monitor #(.OCC_TARGET(N)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_i         (ev),
        .rsp_i        (rsp),
        .viol_flags_o (flags),
        .viol_code_o  (code),
        .pass_o       (pass),
        .occ_count_o  (cnt)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    // Hold one input pair over a single edge, then settle after it.
    task automatic step(input logic a, input logic o);
        ev  = a;
        rsp = o;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(0, 0);
        step(0, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R1 count", cnt, 0);
        check("R1 flags", flags, 0);
        check("R1 code", code, 0);
        check("R1 pass", pass, 0);
    endtask

    task automatic t_scattered_pass();
        do_reset();
        step(0, 0);
        step(1, 0);
        for (int i = 0; i < 3000; i++) step(0, 0);
        step(1, 0);
        step(0, 0);
        step(1, 0);
        step(1, 0);
        check("R3 count after gaps", cnt, 4);
        check("R3 no flags yet", flags, 0);
        step(1, 1);
        check("R4 pass", pass, 1);
        check("R4 count", cnt, 5);
        check("R4 flags clean", flags, 0);
        step(1, 0);
        step(1, 0);
        check("R3 saturate", cnt, 5);
        check("R4 pass held", pass, 1);
    endtask

    task automatic t_initial();
        do_reset();
        step(0, 1);
        check("R2 flags init+orphan", flags, 5'b01001);
        check("R9 priority code", code, 1);
        do_reset();
        check("R10 flags cleared", flags, 0);
        step(0, 0);
        step(0, 0);
        check("R10 no flag when low", flags, 0);
        do_reset();
        step(1, 1);
        check("R10 rearmed flags", flags, 5'b00011);
        check("R10 rearmed code", code, 1);
    endtask

    task automatic t_early();
        do_reset();
        step(1, 0);
        step(1, 1);
        check("R6 early flags", flags, 5'b00010);
        check("R6 early code", code, 2);
        step(0, 1);
        check("R9 sticky plus orphan", flags, 5'b01010);
        check("R9 first code kept", code, 2);
    endtask

    task automatic t_missed();
        do_reset();
        for (int i = 0; i < N; i++) step(1, 0);
        check("R5 missed flags", flags, 5'b00100);
        check("R5 missed code", code, 3);
        check("R5 no pass", pass, 0);
    endtask

    task automatic t_repeat();
        do_reset();
        for (int i = 0; i < N - 1; i++) step(1, 0);
        step(1, 1);
        check("R8 pass before repeat", pass, 1);
        step(1, 1);
        check("R8 repeat flags", flags, 5'b10000);
        check("R8 repeat code", code, 5);
        check("R8 pass cleared", pass, 0);
    endtask

    task automatic t_orphan();
        do_reset();
        step(0, 0);
        step(0, 1);
        check("R7 orphan flags", flags, 5'b01000);
        check("R7 orphan code", code, 4);
        check("R7 count untouched", cnt, 0);
    endtask

    initial begin
        t_reset_state();
        t_scattered_pass();
        t_initial();
        t_early();
        t_missed();
        t_repeat();
        t_orphan();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule